// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the write-side front end of a legacy-style programmable interrupt controller. It watches byte writes on two ports, a base port and an odd port, and runs the fixed initialization handshake. A base-port write with bit 4 set always opens a new sequence. The next three odd-port writes are then taken as the second, third and fourth initialization words. After that, base-port writes with bit 4 clear are passed on as operation command words.

The block keeps the five high vector bits and the cascade byte that the sequence programs. It raises an initialized flag once the sequence is complete. It also flags any initialization word whose fixed or reserved bits hold the wrong value, but it still accepts that word. Cascade operation and the fourth word are always on. Trigger mode is set by a separate edge/level register, so the trigger-mode bit of the first word has no effect here. The same RTL serves the master and the slave through the `IS_SLAVE` parameter.

Top module: `icwInitSeq`

## Requirements
- R1: After reset, `initDone`, `protoErr`, `ocw2Strobe` and `ocw3Strobe` are 0 and `vecBase` and `cascadeCfg` are 0. Odd-port writes (`addrOdd`=1) made before any first word change none of these outputs.
- R2: A base-port write (`addrOdd`=0) with `wrData[4]`=1 is taken as the first word in every state, including mid-sequence and after completion. It restarts the sequence, and `initDone` is 0 from the next cycle.
- R3: After the first word, the next three odd-port writes are taken in order as words 2, 3 and 4. `initDone` goes to 1 in the cycle after word 4 is accepted and stays 0 before that.
- R4: `vecBase` takes `wrData[7:3]` of word 2 in the cycle after that word is accepted. At all other times it holds its value.
- R5: `cascadeCfg` takes all eight bits of word 3 in the cycle after that word is accepted. On the master this byte is the request-line mask of the slave connection.
- R6: In the first word, bit 3 (trigger mode) and bit 2 are ignored. Any value of these bits gives the same outputs, and neither bit sets `protoErr`.
- R7: When a new first word is accepted, `protoErr` is set to 1 if that word has `wrData[7:5]`≠0, bit 1=1 or bit 0=0, and cleared otherwise. Later in the same sequence it is also set if word 2 has `wrData[2:0]`≠0. On the slave (`IS_SLAVE`=1) it is also set if word 3 is not 8'h04. A word that sets `protoErr` is still accepted.
- R8: After initialization, a base-port write with bit 4=0 and bit 3=0 pulses `ocw2Strobe` for one cycle, starting in the next cycle. With bit 3=1 it pulses `ocw3Strobe` in the same way. `ocwData` carries the written byte while either strobe is high, and the two strobes are never high together.
- R9: Base-port writes with bit 4=0 made before initialization is complete give no strobe. They leave `initDone`, `vecBase` and `cascadeCfg` unchanged and do not advance the sequence.
- R10: Odd-port writes after initialization is complete change none of `vecBase`, `cascadeCfg`, `initDone` or `protoErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| addrOdd | input | 1 | 0 selects the base port, 1 selects the odd port |
| wrData | input | 8 | Write data byte |
| initDone | output | 1 | Initialization sequence complete |
| vecBase | output | 5 | Upper five bits of the interrupt vector |
| cascadeCfg | output | 8 | Cascade byte from word 3 |
| protoErr | output | 1 | A fixed or reserved bit was wrong in the current sequence |
| ocw2Strobe | output | 1 | One-cycle pulse for operation command word 2 |
| ocw3Strobe | output | 1 | One-cycle pulse for operation command word 3 |
| ocwData | output | 8 | Byte belonging to the current command-word strobe |

## Verification
The sequence is first run in its clean order. This shows that each odd write lands in the right field and that the completion flag rises only after word 4. It is then rerun with a restart in the middle, after word 2, and a restart after completion, which separates a true restart from simply continuing the old count. Stray base writes before completion and odd writes after it show that the sequence is not disturbed by writes out of order. Command-word writes with bit 3 both clear and set show that the two strobes are routed separately. Words with bad fixed bits, sent to a master and a slave together, show where the error checks differ between the two roles.

// File: rtl/icwSeqPkg.sv
package icwSeqPkg;
  localparam int DATA_W = 8;
  localparam int VEC_W  = 5;

  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_WANT2  = 3'd1,
    ST_WANT3  = 3'd2,
    ST_WANT4  = 3'd3,
    ST_READY  = 3'd4
  } seqState_t;

  typedef struct packed {
    logic capW1;
    logic capW2;
    logic capW3;
    logic capW4;
    logic fireOcw2;
    logic fireOcw3;
  } seqStrobes_t;
endpackage

// File: rtl/icwSeqCtrl.sv
module icwSeqCtrl
  import icwSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addrOdd,
  input  logic [DATA_W-1:0] wrData,
  output seqStrobes_t       stb,
  output logic              initDone
);
  localparam int SEL_BIT = 4;
  localparam int OCW_BIT = 3;

  seqState_t state, stateNext;

  logic baseWr, oddWr, isFirst;
  assign baseWr  = wrEn && !addrOdd;
  assign oddWr   = wrEn && addrOdd;
  assign isFirst = baseWr && wrData[SEL_BIT];

  always_comb begin
    stb       = '0;
    stateNext = state;
    if (isFirst) begin
      stb.capW1 = 1'b1;
      stateNext = ST_WANT2;
    end else begin
      unique case (state)
        ST_WANT2: if (oddWr) begin stb.capW2 = 1'b1; stateNext = ST_WANT3; end
        ST_WANT3: if (oddWr) begin stb.capW3 = 1'b1; stateNext = ST_WANT4; end
        ST_WANT4: if (oddWr) begin stb.capW4 = 1'b1; stateNext = ST_READY; end
        ST_READY: if (baseWr) begin
          stb.fireOcw2 = !wrData[OCW_BIT];
          stb.fireOcw3 = wrData[OCW_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_UNINIT;
    else       state <= stateNext;
  end

  assign initDone = (state == ST_READY);

  a_r2_first_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addrOdd && wrData[SEL_BIT]) |=> (state == ST_WANT2 && !initDone));
  a_r3_done_after_w4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WANT4 && wrEn && addrOdd) |=> initDone);
  a_r1_odd_ignored_uninit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UNINIT && !(wrEn && !addrOdd)) |=> (state == ST_UNINIT));
  a_r9_base_no_advance: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_READY && wrEn && !addrOdd && !wrData[SEL_BIT]) |=> $stable(state));
  a_r8_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capW1, stb.capW2, stb.capW3, stb.capW4, stb.fireOcw2, stb.fireOcw3}));
endmodule

// File: rtl/icwSeqData.sv
module icwSeqData
  import icwSeqPkg::*;
#(
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  seqStrobes_t       stb,
  output logic [VEC_W-1:0]  vecBase,
  output logic [DATA_W-1:0] cascadeCfg,
  output logic              protoErr,
  output logic              ocw2Strobe,
  output logic              ocw3Strobe,
  output logic [DATA_W-1:0] ocwData
);
  localparam int LOW_W = DATA_W - VEC_W;
  localparam logic [DATA_W-1:0] SLAVE_W3 = DATA_W'(8'h04);

  logic w1Bad, w2Bad, w3Bad;
  assign w1Bad = (wrData[7:5] != 3'b000) || wrData[1] || !wrData[0];
  assign w2Bad = (wrData[LOW_W-1:0] != '0);

  generate
    if (IS_SLAVE) begin : g_slaveChk
      assign w3Bad = (wrData != SLAVE_W3);
    end else begin : g_masterChk
      assign w3Bad = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecBase    <= '0;
      cascadeCfg <= '0;
      protoErr   <= 1'b0;
      ocw2Strobe <= 1'b0;
      ocw3Strobe <= 1'b0;
      ocwData    <= '0;
    end else begin
      ocw2Strobe <= stb.fireOcw2;
      ocw3Strobe <= stb.fireOcw3;
      if (stb.fireOcw2 || stb.fireOcw3) ocwData <= wrData;
      if (stb.capW1)      protoErr <= w1Bad;
      else if (stb.capW2) protoErr <= protoErr | w2Bad;
      else if (stb.capW3) protoErr <= protoErr | w3Bad;
      if (stb.capW2) vecBase    <= wrData[DATA_W-1:LOW_W];
      if (stb.capW3) cascadeCfg <= wrData;
    end
  end

  a_r4_vec_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capW2 |=> $stable(vecBase));
  a_r5_cas_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capW3 |=> $stable(cascadeCfg));
  a_r8_ocw_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ocw2Strobe, ocw3Strobe}));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (protoErr && !stb.capW1) |=> protoErr);
endmodule

// File: rtl/icwInitSeq.sv
module icwInitSeq
  import icwSeqPkg::*;
#(
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        addrOdd,
  input  logic [7:0]  wrData,
  output logic        initDone,
  output logic [4:0]  vecBase,
  output logic [7:0]  cascadeCfg,
  output logic        protoErr,
  output logic        ocw2Strobe,
  output logic        ocw3Strobe,
  output logic [7:0]  ocwData
);
  seqStrobes_t stb;

  icwSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addrOdd(addrOdd),
    .wrData(wrData), .stb(stb), .initDone(initDone)
  );

  icwSeqData #(.IS_SLAVE(IS_SLAVE)) u_data (
    .clk(clk), .rstN(rstN), .wrData(wrData), .stb(stb),
    .vecBase(vecBase), .cascadeCfg(cascadeCfg), .protoErr(protoErr),
    .ocw2Strobe(ocw2Strobe), .ocw3Strobe(ocw3Strobe), .ocwData(ocwData)
  );

  a_r10_odd_after_done: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && wrEn && addrOdd) |=> ($stable(vecBase) && $stable(cascadeCfg) && initDone));
endmodule

// File: tb/icwInitSeq_bench.sv
module icwInitSeq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic addrOdd = 1'b0;
  logic [7:0] wrData = '0;
  logic initDone, protoErr, ocw2Strobe, ocw3Strobe;
  logic [4:0] vecBase;
  logic [7:0] cascadeCfg, ocwData;
  logic sDone, sErr, sO2, sO3;
  logic [4:0] sVec;
  logic [7:0] sCas, sOd;

  int nRun = 0;
  int nFail = 0;
  logic [8:0] expQ[$];

  always #5 clk = ~clk;

  icwInitSeq u_icwInitSeq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addrOdd(addrOdd), .wrData(wrData),
    .initDone(initDone), .vecBase(vecBase), .cascadeCfg(cascadeCfg),
    .protoErr(protoErr), .ocw2Strobe(ocw2Strobe), .ocw3Strobe(ocw3Strobe),
    .ocwData(ocwData)
  );

  icwInitSeq #(.IS_SLAVE(1'b1)) u_icwInitSeqSlave (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addrOdd(addrOdd), .wrData(wrData),
    .initDone(sDone), .vecBase(sVec), .cascadeCfg(sCas),
    .protoErr(sErr), .ocw2Strobe(sO2), .ocw3Strobe(sO3), .ocwData(sOd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic odd, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addrOdd = odd; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addrOdd = 1'b0; wrData = '0;
  endtask

  // R8 driver: expected command-word event is {isOcw3, byte}
  task automatic ocw(input logic [7:0] d);
    expQ.push_back({d[3], d});
    wr(1'b0, d);
  endtask

  // R8 monitor: scoreboard pops one item per strobe pulse
  always @(negedge clk) begin
    if (rstN && (ocw2Strobe || ocw3Strobe)) begin
      if (expQ.size() == 0) check("R8 unexpected strobe", {ocw3Strobe, ocwData}, 9'h1ff);
      else begin
        logic [8:0] e;
        e = expQ.pop_front();
        check("R8 strobe kind/data", {ocw3Strobe, ocwData}, e);
        check("R8 strobes exclusive", ocw2Strobe & ocw3Strobe, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 done", initDone, 0);
    check("R1 err", protoErr, 0);
    check("R1 strobes", {ocw2Strobe, ocw3Strobe}, 0);
    wr(1'b1, 8'hF8);
    check("R1 odd ignored vec", vecBase, 0);
    check("R1 odd ignored done", initDone, 0);

    // clean sequence; R6: bits 3 and 2 set in word 1
    wr(1'b0, 8'h1D);
    check("R6 no err", protoErr, 0);
    wr(1'b0, 8'h0A);                       // R9: stray base write mid-sequence
    check("R9 no done", initDone, 0);
    wr(1'b1, 8'hA8);
    check("R4 vec", vecBase, 5'h15);
    check("R3 not done after w2", initDone, 0);
    wr(1'b1, 8'h04);
    check("R5 cascade", cascadeCfg, 8'h04);
    check("R9 vec untouched", vecBase, 5'h15);
    check("R3 not done after w3", initDone, 0);
    wr(1'b1, 8'h01);
    check("R3 done", initDone, 1);
    check("R7 slave clean", sErr, 0);

    ocw(8'h20);
    ocw(8'h0B);
    ocw(8'h60);
    wr(1'b1, 8'h58);                       // R10: odd write after done
    check("R10 vec", vecBase, 5'h15);
    check("R10 done", initDone, 1);

    // R2: restart after completion, then mid-sequence
    wr(1'b0, 8'h11);
    check("R2 done drops", initDone, 0);
    wr(1'b1, 8'h40);
    check("R4 vec2", vecBase, 5'h08);
    wr(1'b0, 8'h11);
    wr(1'b1, 8'hF0);
    check("R2 restart vec", vecBase, 5'h1E);
    wr(1'b1, 8'h02);
    check("R5 cas master mask", cascadeCfg, 8'h02);
    check("R7 slave bad w3", sErr, 1);
    check("R7 master w3 free", protoErr, 0);
    wr(1'b1, 8'h01);
    check("R3 done again", initDone, 1);

    // R7: bad word 1 still accepted, then bad word 2
    wr(1'b0, 8'h32);
    check("R7 w1 bad", protoErr, 1);
    check("R7 w1 accepted", initDone, 0);
    wr(1'b0, 8'h11);
    check("R7 clean w1 clears", protoErr, 0);
    wr(1'b1, 8'h83);
    check("R7 w2 bad", protoErr, 1);
    check("R7 w2 accepted", vecBase, 5'h10);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h01);
    check("R7 sticky", protoErr, 1);
    ocw(8'h08);

    repeat (3) @(negedge clk);
    check("R8 queue drained", expQ.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule